// File: doc/BRIEF.md
# Clock Divider and Reset Sequencer

This block produces the core clock and the conditioned reset for a small processor. A free-running flip-flop on the fast oscillator clock halves its frequency, giving a square core clock that never stops, including while reset is active. The raw reset pin is active low and may change at any time. It is taken into the core clock domain through a short synchronizer chain and a registered output stage, so the reset seen by the rest of the chip is active high and moves only on rising core clock edges.

The block also decides when the core may start fetching instructions. It counts how long reset was held. A reset that lasted long enough marks initialization as valid, and a fetch-enable strobe rises a fixed number of core cycles after the pin is released. A reset that was too short leaves initialization invalid, and fetch stays off until a long enough reset arrives. The block has no data streams, so every pin is a plain control or status signal.

Top module: `clk_reset_seq`

## Requirements
- R1: `core_clk` toggles on every rising edge of `osc_clk`, so it has half the oscillator frequency and a 50% duty cycle. It keeps running while reset is active.
- R2: When `rst_pin_n` goes low, `core_rst` is 1 after the first rising edge of `core_clk` that follows the fall, even if the pin returns high before that edge.
- R3: `core_rst` changes only just after a rising edge of `core_clk`, and never in the half period that follows a falling edge.
- R4: Let n be the number of rising `core_clk` edges at which `rst_pin_n` is sampled low. `core_rst` then stays high for exactly n + 2 core clock periods, where 2 is the number of synchronizer stages.
- R5: `init_ok` is 0 while `core_rst` is 1. After `core_rst` falls, `init_ok` is 1 if n is 5 or more, and 0 if n is 4 or fewer.
- R6: After a reset that sets `init_ok`, `fetch_en` rises at the 6th rising `core_clk` edge after `rst_pin_n` returns high. That is 3 edges after `core_rst` falls, and `fetch_en` is 0 at the two edges before it.
- R7: After a reset that leaves `init_ok` at 0, including the power-up release, `fetch_en` stays 0 until a later reset sets `init_ok`.
- R8: `fetch_en` is 0 in every cycle in which `core_rst` is 1. Once `fetch_en` is 1, it stays 1 until the next reset.
- R9: A new reset that follows a valid one clears both `fetch_en` and `init_ok`. If the new reset is too short, both stay at 0 after its release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Fast oscillator clock, twice the core frequency |
| rst_pin_n | input | 1 | Raw asynchronous reset, active low |
| core_clk | output | 1 | Divided square core clock |
| core_rst | output | 1 | Synchronized reset for the core, active high |
| fetch_en | output | 1 | Instruction fetch may begin, sticky until the next reset |
| init_ok | output | 1 | The last reset was held long enough to be valid |

## Verification
Two events can land on the same core clock edge: `core_rst` rising because the pin has dropped, and `fetch_en` being forced off. To provoke this, the bench drops the pin while fetch is already enabled, first after a long reset and then with a short reset that follows a valid one. At every core cycle in which `core_rst` reads high, the bench requires `fetch_en` to read 0 and checks that `init_ok` is cleared. The reset lengths are 0, 4, 5, 8 and 12 edges, which brackets the qualification threshold at 4 and 5. The bench also times each `fetch_en` rise to the exact edge.

// File: rtl/clkrst_pkg.sv
`timescale 1ns/1ps
package clkrst_pkg;

  // Sequencer phase after the conditioned reset
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,  // core reset is active
    ST_WAIT = 2'd1,  // released and valid, counting toward fetch
    ST_RUN  = 2'd2,  // fetch allowed
    ST_IDLE = 2'd3   // released but not validly initialized
  } seq_state_e;

  // Bits needed to hold values 0..max
  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/clkrst_div2.sv
`timescale 1ns/1ps
module clkrst_div2 (
  input  logic osc_clk,
  output logic clk_out
);

  // Intentionally not reset, so the divided clock keeps running through reset
  logic phase_q = 1'b0;

  always_ff @(posedge osc_clk) begin
    phase_q <= ~phase_q;
  end

  assign clk_out = phase_q;

endmodule

// File: rtl/clkrst_sync.sv
`timescale 1ns/1ps
module clkrst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_raw,
  output logic rst_out
);

  logic [STAGES-1:0] chain_q = '0;
  logic              rst_q   = 1'b1;

  // Assertion is asynchronous, release walks through the chain
  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n_raw) begin
        if (!rst_n_raw) chain_q <= '0;
        else            chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n_raw) begin
        if (!rst_n_raw) chain_q <= '0;
        else            chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  // Output stage keeps every reset edge on a rising clock edge
  always_ff @(posedge clk) begin
    rst_q <= ~chain_q[STAGES-1];
  end

  assign rst_out = rst_q;

endmodule

// File: rtl/clkrst_seq.sv
`timescale 1ns/1ps
module clkrst_seq
  import clkrst_pkg::*;
#(
  parameter int unsigned MIN_LOW_CYCLES = 5,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned FETCH_LATENCY  = 6
) (
  input  logic clk,
  input  logic rst_in,
  output logic fetch_en,
  output logic init_ok
);

  // Reset cycles seen here = pin-low edges + synchronizer depth
  localparam int unsigned QUAL_CNT = MIN_LOW_CYCLES + SYNC_STAGES;
  localparam int unsigned CW       = cnt_width(QUAL_CNT);
  // Edges spent before this stage sees the release: chain + output register
  localparam int unsigned WAIT_CYC = FETCH_LATENCY - SYNC_STAGES - 1;
  localparam int unsigned WW       = cnt_width(WAIT_CYC);

  localparam logic [CW-1:0] QUAL_MAX  = CW'(QUAL_CNT);
  localparam logic [CW-1:0] QUAL_M1   = CW'(QUAL_CNT - 1);
  localparam logic [WW-1:0] WAIT_LAST = WW'(WAIT_CYC - 1);
  localparam logic [WW-1:0] WAIT_ONE  = WW'(1);

  logic [CW-1:0] low_cnt_q = '0;
  logic          qual_q    = 1'b0;
  logic [WW-1:0] wait_q    = '0;
  seq_state_e    state_q   = ST_IDLE;

  always_ff @(posedge clk) begin
    if (rst_in) begin
      if (low_cnt_q != QUAL_MAX) low_cnt_q <= low_cnt_q + CW'(1);
      qual_q  <= (low_cnt_q >= QUAL_M1);
      state_q <= ST_HOLD;
      wait_q  <= '0;
    end else begin
      low_cnt_q <= '0;
      unique case (state_q)
        ST_HOLD: begin
          wait_q <= WAIT_ONE;
          if (!qual_q)            state_q <= ST_IDLE;
          else if (WAIT_CYC <= 1) state_q <= ST_RUN;
          else                    state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wait_q == WAIT_LAST) state_q <= ST_RUN;
          else                     wait_q  <= wait_q + WW'(1);
        end
        default: ;
      endcase
    end
  end

  assign fetch_en = (state_q == ST_RUN) && !rst_in;
  assign init_ok  = qual_q && !rst_in;

endmodule

// File: rtl/clk_reset_seq.sv
`timescale 1ns/1ps
module clk_reset_seq #(
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned MIN_LOW_CYCLES = 5,
  parameter int unsigned FETCH_LATENCY  = 6
) (
  input  logic osc_clk,
  input  logic rst_pin_n,
  output logic core_clk,
  output logic core_rst,
  output logic fetch_en,
  output logic init_ok
);

  clkrst_div2 u_div (
    .osc_clk (osc_clk),
    .clk_out (core_clk)
  );

  clkrst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk       (core_clk),
    .rst_n_raw (rst_pin_n),
    .rst_out   (core_rst)
  );

  clkrst_seq #(
    .MIN_LOW_CYCLES (MIN_LOW_CYCLES),
    .SYNC_STAGES    (SYNC_STAGES),
    .FETCH_LATENCY  (FETCH_LATENCY)
  ) u_seq (
    .clk      (core_clk),
    .rst_in   (core_rst),
    .fetch_en (fetch_en),
    .init_ok  (init_ok)
  );

endmodule

// File: rtl/clkrst_checks.sv
`timescale 1ns/1ps
module clkrst_checks (
  input logic osc_clk,
  input logic rst_pin_n,
  input logic core_clk,
  input logic core_rst,
  input logic fetch_en,
  input logic init_ok
);

  logic [1:0] warm_q = 2'd0;
  logic       ready;

  always_ff @(posedge osc_clk) begin
    if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end
  assign ready = (warm_q == 2'd3);

  // R1: divided clock flips at every oscillator edge, reset or not
  a_r1_div_toggle: assert property (@(posedge osc_clk) disable iff (!ready)
    core_clk != $past(core_clk));

  // R3: no reset change in the window after a falling core edge
  a_r3_rst_on_rise: assert property (@(posedge osc_clk) disable iff (!ready)
    !core_clk |-> $stable(core_rst));

  // R6: fetch never comes up in the cycle reset is released
  a_r6_no_early_fetch: assert property (@(posedge core_clk) disable iff (!ready)
    $fell(core_rst) |-> !fetch_en);

  // R7: fetch can only be enabled when initialization is valid
  a_r7_fetch_needs_ok: assert property (@(posedge core_clk) disable iff (!ready)
    fetch_en |-> init_ok);

  // R7: a rise of fetch follows a cycle with valid initialization
  a_r7_rise_after_ok: assert property (@(posedge core_clk) disable iff (!ready)
    $rose(fetch_en) |-> $past(init_ok));

  // R8: outside reset, fetch enable is sticky
  a_r8_fetch_sticky: assert property (@(posedge core_clk) disable iff (!ready || core_rst || !rst_pin_n)
    $past(fetch_en) |-> fetch_en);

endmodule

bind clk_reset_seq clkrst_checks u_checks (
  .osc_clk   (osc_clk),
  .rst_pin_n (rst_pin_n),
  .core_clk  (core_clk),
  .core_rst  (core_rst),
  .fetch_en  (fetch_en),
  .init_ok   (init_ok)
);

// File: tb/test_clk_reset_seq.sv
`timescale 1ns/1ps
module test_clk_reset_seq;

  logic osc_clk   = 1'b0;
  logic rst_pin_n = 1'b1;
  logic core_clk, core_rst, fetch_en, init_ok;

  always #2.5 osc_clk = ~osc_clk;  // 200 MHz

  clk_reset_seq i_clk_reset_seq (
    .osc_clk   (osc_clk),
    .rst_pin_n (rst_pin_n),
    .core_clk  (core_clk),
    .core_rst  (core_rst),
    .fetch_en  (fetch_en),
    .init_ok   (init_ok)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct {
    int len;
    bit ok;
  } exp_t;
  exp_t exp_q[$];

  bit mon_on   = 1'b0;
  int mon_done = 0;

  // Clock divide and reset-edge observers, sampled at oscillator falling edges
  bit arm      = 1'b0;
  logic prev_clk, prev_rst;
  int div_err  = 0;
  int edge_err = 0;
  int toggles  = 0;

  always @(negedge osc_clk) begin
    if (arm) begin
      if (core_clk === prev_clk) div_err++;
      else toggles++;
      if (core_rst !== prev_rst && core_clk !== 1'b1) edge_err++;
    end
    prev_clk = core_clk;
    prev_rst = core_rst;
    arm = 1'b1;
  end

  // Monitor: measures each reset and fetch timing, compares with expected items
  initial begin
    wait (mon_on);
    forever begin
      int len, bad_fetch, bad_ok;
      exp_t e;
      @(posedge core_rst);
      len = 0; bad_fetch = 0; bad_ok = 0;
      forever begin
        @(negedge core_clk);
        if (!core_rst) break;
        len++;
        if (fetch_en) bad_fetch++;
        if (init_ok)  bad_ok++;
      end
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "unexpected reset", len, 0);
      end else begin
        e = exp_q.pop_front();
        check(len == e.len, "R4", "reset length", len, e.len);
        check(bad_fetch == 0, "R8", "fetch during reset", bad_fetch, 0);
        check(bad_ok == 0, "R5", "init_ok during reset", bad_ok, 0);
        check(init_ok == e.ok, "R5", "init_ok after release", int'(init_ok), int'(e.ok));
        if (e.ok) begin
          logic f4, f5, f6;
          int drop;
          @(negedge core_clk); f4 = fetch_en;
          @(negedge core_clk); f5 = fetch_en;
          @(negedge core_clk); f6 = fetch_en;
          check(!f4 && !f5, "R6", "fetch before sixth edge", int'(f4) + int'(f5), 0);
          check(f6, "R6", "fetch at sixth edge", int'(f6), 1);
          drop = 0;
          repeat (4) begin
            @(negedge core_clk);
            if (!fetch_en) drop++;
          end
          check(drop == 0, "R8", "fetch sticky", drop, 0);
        end else begin
          int hold;
          hold = 0;
          repeat (10) begin
            @(negedge core_clk);
            if (fetch_en) hold++;
          end
          check(hold == 0, "R7", "fetch after short reset", hold, 0);
        end
      end
      mon_done++;
    end
  end

  int issued = 0;

  // Driver: pulls the pin low across n rising core edges, pushes expectations
  task automatic do_reset(input int n);
    exp_t e;
    e.len = n + 2;
    e.ok  = (n >= 5);
    @(posedge core_clk);
    #3;
    exp_q.push_back(e);
    issued++;
    rst_pin_n = 1'b0;
    if (n == 0) #1 rst_pin_n = 1'b1;
    @(posedge core_clk);
    #2;
    check(core_rst === 1'b1, "R2", "reset after first edge", int'(core_rst), 1);
    if (n > 0) begin
      repeat (n - 1) @(posedge core_clk);
      #3 rst_pin_n = 1'b1;
    end
    repeat (16) @(posedge core_clk);
    wait (mon_done == issued);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      begin
        repeat (10) @(posedge core_clk);
        #2;
        // Power-up release never qualifies: reset state
        check(core_rst === 1'b0, "R4", "reset state core_rst", int'(core_rst), 0);
        check(init_ok === 1'b0, "R7", "reset state init_ok", int'(init_ok), 0);
        check(fetch_en === 1'b0, "R7", "reset state fetch_en", int'(fetch_en), 0);
        mon_on = 1'b1;
        do_reset(8);
        do_reset(4);   // boundary: too short
        do_reset(5);   // boundary: just long enough
        do_reset(0);   // glitch between edges
        do_reset(12);
        do_reset(4);   // R9: short reset after a valid one
        check(fetch_en === 1'b0 && init_ok === 1'b0, "R9", "cleared after short reset",
              int'(fetch_en) + int'(init_ok), 0);
        check(div_err == 0 && toggles > 100, "R1", "clock toggle errors", div_err, 0);
        check(edge_err == 0, "R3", "reset off-edge changes", edge_err, 0);
      end
      begin
        #200us;
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) begin
      checks++;
      fails++;
      $display("FAIL all watchdog: actual %0d expected %0d", 1, 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule